// File: doc/BRIEF.md
# Bitplane Fetch Slot Sequencer

This block decides, cycle by cycle inside a data-fetch window, whether a bitplane word is fetched and which plane it belongs to. Three settings shape the schedule: a raw 2-bit fetch-mode code, a display resolution code and a requested plane count. From these it derives how long the repeating slot block is, how many planes can fit into that block, the order in which planes take their slots, and how many slots in each block stay free for other bus users. A plane count that does not fit disables plane fetching. One compatibility case on the older chipset variant reduces seven requested planes to four.

A pulse on the start input opens the window and restarts the slot counter. A stop request does not end the window at once. The window closes only after a whole number of fetch units has elapsed since the start. Memory addressing, modulo handling and pixel shifting are done by neighbouring logic, which acts on the fetch flag and plane number this block produces.

Top module: `bpl_fetch_seq`

## Requirements
- R1: The raw fetch-mode code maps to an internal mode: code 0 gives mode 0, codes 1 and 2 give mode 1, and code 3 gives mode 2.
- R2: Resolution code 0 means low, 1 means high, 2 means super-high, and 3 behaves as super-high. The plane limit is 8/4/2 for low/high/super-high in mode 0, 8/8/4 in mode 1, and 8 at every resolution in mode 2.
- R3: The slot block is 8/4/2 cycles long (low/high/super-high) in mode 0, 16/8/4 in mode 1 and 32/16/8 in mode 2. The slot index is the number of cycles since the window opened, modulo the block length.
- R4: When the plane limit is 8, slot indices 0..7 carry planes 8,4,6,2,7,3,5,1. When the limit is 4, indices 0..3 carry 4,2,3,1. When the limit is 2, indices 0..1 carry 2,1. A slot fetches only if its plane is at most the effective plane count; then `fetch_valid_o`=1 and `plane_o` holds the plane. Otherwise both are 0, and slots at or beyond the limit are always free.
- R5: A requested plane count above the plane limit, including any value above 8, gives an effective count of 0, and no plane is fetched.
- R6: With `legacy_i`=1 in mode 0 at low resolution, a request of 7 planes gives an effective count of 4. With `legacy_i`=0 it stays 7.
- R7: `free_cycles_o` equals the block length minus the effective plane count for the current settings.
- R8: A start pulse sampled at a clock edge makes the window active from the next cycle, with slot index 0. This also applies while a window is already open, in which case the counter restarts.
- R9: Once a stop request has been sampled, it is held. The window's last active cycle is the first cycle whose count since the start, plus one, is a multiple of the fetch unit. The fetch unit is 8/8/8 in mode 0, 16/8/8 in mode 1 and 32/16/8 in mode 2, for low/high/super-high.
- R10: After reset the window is inactive and no fetch is flagged.
- R11: If start and stop are sampled in the same cycle, the start wins and leaves no pending stop.
- R12: Outside the window, no fetch is flagged, and a stop request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmode_i | input | 2 | Raw fetch-mode code |
| res_i | input | 2 | Resolution code |
| planes_i | input | 4 | Requested plane count |
| legacy_i | input | 1 | Older chipset variant behaviour |
| win_start_i | input | 1 | Open or restart the fetch window |
| win_stop_i | input | 1 | Request window close at next unit boundary |
| fetch_valid_o | output | 1 | This cycle fetches a plane |
| plane_o | output | 4 | Plane number fetched, 0 when none |
| active_o | output | 1 | Fetch window open |
| free_cycles_o | output | 6 | Free slots per block |
| eff_planes_o | output | 4 | Effective plane count |

## Verification
A slot counter that is out of step with the window start shows up in the first block after the start. The plane sequence is then rotated, and the fetch flag appears on slots that should be idle. A lost or stuck pending stop shows up as a window that closes one fetch unit early or late, or never closes, and this is visible on `active_o` by the next unit boundary. A wrong limit or block-length table shows up at once in `eff_planes_o` and `free_cycles_o`, without any window activity. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/bpl_seq_pkg.sv
package bpl_seq_pkg;
  localparam int PLANE_W = 4;
  localparam int EXP_W   = 3;
  localparam int FREE_W  = 6;
  localparam int LEGACY_REQ = 7;
  localparam int LEGACY_EFF = 4;

  typedef enum logic [1:0] {FM_X1 = 2'd0, FM_X2 = 2'd1, FM_X4 = 2'd2} fetch_mode_e;
  typedef enum logic [1:0] {RES_LO = 2'd0, RES_HI = 2'd1, RES_SH = 2'd2} res_e;

  function automatic fetch_mode_e map_mode(logic [1:0] raw);
    case (raw)
      2'd0:    return FM_X1;
      2'd3:    return FM_X4;
      default: return FM_X2;
    endcase
  endfunction

  function automatic res_e map_res(logic [1:0] raw);
    case (raw)
      2'd0:    return RES_LO;
      2'd1:    return RES_HI;
      default: return RES_SH;
    endcase
  endfunction

  // log2 of the plane limit
  function automatic logic [EXP_W-1:0] max_exp(fetch_mode_e fm, res_e rs);
    case (fm)
      FM_X1:   return EXP_W'(3 - int'(rs));
      FM_X2:   return (rs == RES_SH) ? EXP_W'(2) : EXP_W'(3);
      default: return EXP_W'(3);
    endcase
  endfunction

  // log2 of the slot block length
  function automatic logic [EXP_W-1:0] blk_exp(fetch_mode_e fm, res_e rs);
    return EXP_W'(3 + int'(fm) - int'(rs));
  endfunction

  // log2 of the fetch unit used for stop alignment
  function automatic logic [EXP_W-1:0] unit_exp(fetch_mode_e fm, res_e rs);
    case (fm)
      FM_X1:   return EXP_W'(3);
      FM_X2:   return (rs == RES_LO) ? EXP_W'(4) : EXP_W'(3);
      default: return EXP_W'(5 - int'(rs));
    endcase
  endfunction
endpackage

// File: rtl/bpl_cfg_decode.sv
module bpl_cfg_decode
  import bpl_seq_pkg::*;
(
  input  logic [1:0]         fmode_raw_i,
  input  logic [1:0]         res_raw_i,
  input  logic [PLANE_W-1:0] planes_i,
  input  logic               legacy_i,
  output logic [EXP_W-1:0]   max_exp_o,
  output logic [EXP_W-1:0]   blk_exp_o,
  output logic [EXP_W-1:0]   unit_exp_o,
  output logic [PLANE_W-1:0] eff_planes_o,
  output logic [FREE_W-1:0]  free_cycles_o
);
  fetch_mode_e      fm;
  res_e             rs;
  logic [PLANE_W:0] max_planes;

  always_comb begin
    fm         = map_mode(fmode_raw_i);
    rs         = map_res(res_raw_i);
    max_exp_o  = max_exp(fm, rs);
    blk_exp_o  = blk_exp(fm, rs);
    unit_exp_o = unit_exp(fm, rs);
    max_planes = (PLANE_W+1)'(1) << max_exp_o;
    if ({1'b0, planes_i} > max_planes)
      eff_planes_o = '0;
    else if (legacy_i && fm == FM_X1 && rs == RES_LO && planes_i == PLANE_W'(LEGACY_REQ))
      eff_planes_o = PLANE_W'(LEGACY_EFF);
    else
      eff_planes_o = planes_i;
    free_cycles_o = (FREE_W'(1) << blk_exp_o) - FREE_W'(eff_planes_o);
  end
endmodule

// File: rtl/bpl_fetch_window.sv
module bpl_fetch_window
  import bpl_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [EXP_W-1:0] unit_exp_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             act_q, pend_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, unit_mask;
  logic             at_unit_end;

  always_comb begin
    cnt_nxt     = cnt_q + CNT_W'(1);
    unit_mask   = (CNT_W'(1) << unit_exp_i) - CNT_W'(1);
    at_unit_end = (cnt_nxt & unit_mask) == '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_nxt;
      if ((stop_i || pend_q) && at_unit_end) begin
        act_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_q | stop_i;
      end
    end
  end

  assign active_o = act_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/bpl_slot_map.sv
module bpl_slot_map
  import bpl_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MAX_EXP = 3
) (
  input  logic               active_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [EXP_W-1:0]   max_exp_i,
  input  logic [EXP_W-1:0]   blk_exp_i,
  input  logic [PLANE_W-1:0] eff_planes_i,
  output logic               fetch_o,
  output logic [PLANE_W-1:0] plane_o
);
  localparam int IDX_W = MAX_EXP + 2;

  logic [IDX_W:0]     blk_mask, idx;
  logic [PLANE_W-1:0] cand_w [1:MAX_EXP];
  logic [MAX_EXP:1]   inr_w;
  logic [PLANE_W-1:0] cand;
  logic               hit;

  assign blk_mask = ((IDX_W+1)'(1) << blk_exp_i) - (IDX_W+1)'(1);
  assign idx      = {1'b0, cnt_i[IDX_W-1:0]} & blk_mask;

  // plane = limit minus bit-reversed slot index
  for (genvar e = 1; e <= MAX_EXP; e++) begin : g_order
    logic [e-1:0] rev;
    always_comb begin
      for (int b = 0; b < e; b++) rev[b] = idx[e-1-b];
    end
    assign cand_w[e] = PLANE_W'(1 << e) - PLANE_W'(rev);
    assign inr_w[e]  = idx < (IDX_W+1)'(1 << e);
  end

  always_comb begin
    cand = '0;
    hit  = 1'b0;
    for (int e = 1; e <= MAX_EXP; e++) begin
      if (max_exp_i == EXP_W'(e)) begin
        cand = cand_w[e];
        hit  = inr_w[e];
      end
    end
    fetch_o = active_i && hit && (cand != '0) && (eff_planes_i >= cand);
    plane_o = fetch_o ? cand : '0;
  end
endmodule

// File: rtl/bpl_fetch_seq.sv
module bpl_fetch_seq
  import bpl_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MAX_EXP = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         fmode_i,
  input  logic [1:0]         res_i,
  input  logic [PLANE_W-1:0] planes_i,
  input  logic               legacy_i,
  input  logic               win_start_i,
  input  logic               win_stop_i,
  output logic               fetch_valid_o,
  output logic [PLANE_W-1:0] plane_o,
  output logic               active_o,
  output logic [FREE_W-1:0]  free_cycles_o,
  output logic [PLANE_W-1:0] eff_planes_o
);
  logic [EXP_W-1:0] max_exp_w, blk_exp_w, unit_exp_w;
  logic [CNT_W-1:0] cnt_w;

  bpl_cfg_decode u_cfg (
    .fmode_raw_i  (fmode_i),
    .res_raw_i    (res_i),
    .planes_i     (planes_i),
    .legacy_i     (legacy_i),
    .max_exp_o    (max_exp_w),
    .blk_exp_o    (blk_exp_w),
    .unit_exp_o   (unit_exp_w),
    .eff_planes_o (eff_planes_o),
    .free_cycles_o(free_cycles_o)
  );

  bpl_fetch_window #(.CNT_W(CNT_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (win_start_i),
    .stop_i    (win_stop_i),
    .unit_exp_i(unit_exp_w),
    .active_o  (active_o),
    .cnt_o     (cnt_w)
  );

  bpl_slot_map #(.CNT_W(CNT_W), .MAX_EXP(MAX_EXP)) u_map (
    .active_i    (active_o),
    .cnt_i       (cnt_w),
    .max_exp_i   (max_exp_w),
    .blk_exp_i   (blk_exp_w),
    .eff_planes_i(eff_planes_o),
    .fetch_o     (fetch_valid_o),
    .plane_o     (plane_o)
  );
endmodule

// File: rtl/bpl_fetch_seq_chk.sv
module bpl_fetch_seq_chk
  import bpl_seq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               win_start_i,
  input logic               active_o,
  input logic               fetch_valid_o,
  input logic [PLANE_W-1:0] plane_o,
  input logic [PLANE_W-1:0] eff_planes_o,
  input logic [FREE_W-1:0]  free_cycles_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (win_start_i) run_q <= '0;
    else if (active_o)    run_q <= run_q + 8'd1;
  end

  // R4
  plane_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> (plane_o != '0) && (plane_o <= eff_planes_o));

  // R12
  idle_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !fetch_valid_o && (plane_o == '0));

  // R8
  start_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_start_i |=> active_o);

  // R12
  idle_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o && !win_start_i |=> !active_o);

  // R9
  unit_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> (run_q[2:0] == 3'd0));

  // R5
  eff_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_planes_o <= PLANE_W'(8));

  // R7
  free_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cycles_o <= FREE_W'(32));
endmodule

bind bpl_fetch_seq bpl_fetch_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_start_i  (win_start_i),
  .active_o     (active_o),
  .fetch_valid_o(fetch_valid_o),
  .plane_o      (plane_o),
  .eff_planes_o (eff_planes_o),
  .free_cycles_o(free_cycles_o)
);

// File: tb/tb_bpl_fetch_seq.sv
`timescale 1ns/1ps
module tb_bpl_fetch_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fmode = '0, res = '0;
  logic [3:0] planes = '0;
  logic       legacy = 1'b0, start = 1'b0, stop = 1'b0;
  logic       fetch_valid, active;
  logic [3:0] plane, eff_planes;
  logic [5:0] free_cycles;

  int tests = 0, fails = 0;
  int m_act = 0, m_cnt = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  bpl_fetch_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .fmode_i(fmode), .res_i(res),
    .planes_i(planes), .legacy_i(legacy), .win_start_i(start), .win_stop_i(stop),
    .fetch_valid_o(fetch_valid), .plane_o(plane), .active_o(active),
    .free_cycles_o(free_cycles), .eff_planes_o(eff_planes)
  );

  int lim_t  [3][3] = '{'{8, 4, 2}, '{8, 8, 4}, '{8, 8, 8}};
  int blk_t  [3][3] = '{'{8, 4, 2}, '{16, 8, 4}, '{32, 16, 8}};
  int unit_t [3][3] = '{'{8, 8, 8}, '{16, 8, 8}, '{32, 16, 8}};
  int s8 [8] = '{8, 4, 6, 2, 7, 3, 5, 1};
  int s4 [4] = '{4, 2, 3, 1};
  int s2 [2] = '{2, 1};

  function automatic int m_mode();
    if (fmode == 2'd0) return 0;
    if (fmode == 2'd3) return 2;
    return 1;
  endfunction
  function automatic int m_res();
    return (res == 2'd3) ? 2 : int'(res);
  endfunction
  function automatic int m_eff();
    int m = m_mode(), r = m_res();
    if (int'(planes) > lim_t[m][r]) return 0;
    if (legacy && m == 0 && r == 0 && planes == 4'd7) return 4;
    return int'(planes);
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int m = m_mode(), r = m_res(), e = m_eff();
    int ev = 0, ep = 0, idx, c;
    if (m_act != 0) begin
      idx = m_cnt % blk_t[m][r];
      if (idx < lim_t[m][r]) begin
        c = (lim_t[m][r] == 8) ? s8[idx] : (lim_t[m][r] == 4) ? s4[idx] : s2[idx];
        if (e >= c) begin ev = 1; ep = c; end
      end
    end
    chk("R3 R4 fetch", int'(fetch_valid), ev);
    chk("R3 R4 plane", int'(plane), ep);
    chk("R8 R9 R11 R12 window", int'(active), m_act);
    chk("R1 R3 R7 free", int'(free_cycles), blk_t[m][r] - e);
    chk("R2 R5 R6 eff", int'(eff_planes), e);
  endtask

  // inputs set at negedge by caller; compare, then advance model at the edge
  task automatic step();
    int u;
    #1 compare();
    @(posedge clk);
    u = unit_t[m_mode()][m_res()];
    if (start) begin
      m_act = 1; m_cnt = 0; m_pend = 0;
    end else if (m_act != 0) begin
      if ((stop || m_pend != 0) && ((m_cnt + 1) % u == 0)) begin
        m_act = 0; m_pend = 0;
      end else if (stop) m_pend = 1;
      m_cnt++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int guard;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 active", int'(active), 0);
    chk("R10 fetch", int'(fetch_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step();

    // R1 R2 R3 R4 R5 R6 R7 R9 sweep over every setting
    for (int fm = 0; fm < 4; fm++)
      for (int rs = 0; rs < 4; rs++)
        for (int p = 0; p < 10; p++)
          for (int lg = 0; lg < 2; lg++) begin
            fmode = 2'(fm); res = 2'(rs); planes = 4'(p); legacy = lg[0];
            start = 1'b1; step(); start = 1'b0;
            repeat (40) step();
            stop = 1'b1; step(); stop = 1'b0;
            guard = 0;
            while (m_act != 0 && guard < 40) begin step(); guard++; end
            step();
          end

    // R12 stop while idle is ignored
    fmode = 2'd0; res = 2'd0; planes = 4'd6; legacy = 1'b0;
    stop = 1'b1; repeat (3) step(); stop = 1'b0;
    repeat (2) step();

    // R11 start and stop together: start wins, no pending stop
    fmode = 2'd3;
    start = 1'b1; stop = 1'b1; step(); start = 1'b0; stop = 1'b0;
    repeat (70) step();
    chk("R11 still open", int'(active), 1);

    // R8 restart while open, then early stop held pending (R9)
    start = 1'b1; step(); start = 1'b0;
    repeat (5) step();
    stop = 1'b1; step(); stop = 1'b0;
    repeat (40) step();
    chk("R9 closed after unit", int'(active), 0);

    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      start = ($urandom % 16) == 0;
      stop  = ($urandom % 8) == 0;
      if (($urandom % 64) == 0) begin
        fmode = 2'($urandom); res = 2'($urandom);
        planes = 4'($urandom % 10); legacy = 1'($urandom);
      end
      step();
    end
    start = 1'b0; stop = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule